// File: doc/BRIEF.md
# Debug Serial Mailbox Channel

This block is a two-way word mailbox between an external debugger and a processor core. Each channel holds two independent queues. One queue carries words from the core to the debugger; the other carries words from the debugger to the core. The debugger reaches the channels through a small register window. Each channel has three locations: a send location, a receive location and a status location. A single capability register tells the debugger which channels are built.

On the core side, each channel has two valid/ready ports. One port pushes into the core-to-debugger queue and the other pops from the debugger-to-core queue. A debugger write to the send location enqueues a word for the core. A debugger read of the receive location dequeues a word that the core produced. Read data comes back on a registered return path one cycle after the request. The number of channels, the queue depth, the data width and the address width are all parameters.

Top module: `dbg_mailbox`

## Requirements
- R1: Synchronous active-high reset empties both queues of every channel. After reset, `d2c_valid` is 0, `c2d_ready` is 1, and each status word reads 2.
- R2: Channel n decodes its send location at 0x200 + 0x10*n, its receive location at that base + 0x4 and its status location at that base + 0x8. Valid channel numbers are 0 to NUM_CH-1, and NUM_CH is at most 7.
- R3: Status bit 1 reads 1 when the channel's core-to-debugger queue is not full, and 0 when it is full.
- R4: Status bit 0 reads 1 when the channel's debugger-to-core queue holds at least one word, and 0 when it is empty. All other status bits read 0.
- R5: The register at 0x280 has bit n set to 1 for every implemented channel n (n < NUM_CH). Every other bit of that register reads 0.
- R6: A debugger write to a send location enqueues the write data for the core. The core receives the words in the order they were written.
- R7: A debugger read of a receive location returns the oldest core-to-debugger word and removes it from the queue. Words come out in the order the core pushed them.
- R8: A debugger write to a send location while that channel's debugger-to-core queue is full is discarded.
- R9: A read of a receive location while that channel's core-to-debugger queue is empty returns 0 and removes nothing.
- R10: `c2d_ready` is 1 exactly when the core-to-debugger queue is not full, and a word is taken when valid and ready are both 1. `d2c_valid` is 1 exactly when the debugger-to-core queue is not empty. `d2c_valid` and `d2c_data` hold until `d2c_ready` is seen.
- R11: Every debugger read request produces `dbg_rvalid` = 1 with `dbg_rdata` on the next cycle. A write request produces no `dbg_rvalid`.
- R12: The channels are independent. An access to one channel leaves the queues and status of the others unchanged.
- R13: In the same cycle, a queue accepts one push and one pop. If the queue was neither full nor empty, its fill level stays the same and word order is kept.
- R14: Addresses outside the channel windows and the capability register read 0 and ignore writes. This includes channel slots at or above NUM_CH and unused offsets inside a channel slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_req | input | 1 | Debugger access strobe, one cycle per access |
| dbg_we | input | 1 | 1 = write, 0 = read |
| dbg_addr | input | ADDR_W | Debugger byte address |
| dbg_wdata | input | DATA_W | Debugger write data |
| dbg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| dbg_rdata | output | DATA_W | Registered read data |
| c2d_valid | input | NUM_CH | Core offers a word to the debugger, per channel |
| c2d_data | input | NUM_CH*DATA_W | Core words, channel n in slice n |
| c2d_ready | output | NUM_CH | Core-to-debugger queue has space |
| d2c_valid | output | NUM_CH | Debugger-to-core word available |
| d2c_data | output | NUM_CH*DATA_W | Head word for the core, channel n in slice n |
| d2c_ready | input | NUM_CH | Core takes the offered word |

## Verification
Two events can fall in the same cycle on one queue. In the first, the core pushes a word while the debugger's receive read pops the same queue. In the second, the core pops while the debugger writes the send location. The bench creates the first case by driving `c2d_valid` and a receive read in one cycle on a queue that holds three words. It checks that the returned word is the oldest, that the status still shows free space, and that the remaining words drain in order. It creates the second case on a full debugger-to-core queue. There, the bench expects the debugger's word to be discarded while the core still receives the queued head, and it checks the rest of the drain order.

// File: rtl/dbgmb_pkg.sv
package dbgmb_pkg;

  localparam int MB_BASE     = 'h200;
  localparam int MB_CAP_ADDR = 'h280;
  localparam int MB_MAX_CH   = 7;
  localparam int MB_CH_W     = 3;

  localparam logic [3:0] OFF_SEND = 4'h0;
  localparam logic [3:0] OFF_RECV = 4'h4;
  localparam logic [3:0] OFF_STAT = 4'h8;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_SEND,
    ACC_RECV,
    ACC_STAT,
    ACC_CAP
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e            kind;
    logic [MB_CH_W-1:0]   ch;
  } acc_t;

endpackage

// File: rtl/dbgmb_fifo.sv
module dbgmb_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         full,
  output logic         empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  // storage without reset so a RAM primitive can be mapped
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/dbgmb_decode.sv
module dbgmb_decode
  import dbgmb_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc
);

  localparam int SLOT_W = ADDR_W - 4;

  logic [ADDR_W-1:0] rel;
  logic [SLOT_W-1:0] slot;

  assign rel  = addr - ADDR_W'(MB_BASE);
  assign slot = rel[ADDR_W-1:4];

  always_comb begin
    acc.kind = ACC_NONE;
    acc.ch   = '0;
    if (addr == ADDR_W'(MB_CAP_ADDR)) begin
      acc.kind = ACC_CAP;
    end else if (addr >= ADDR_W'(MB_BASE) && slot < SLOT_W'(NUM_CH)) begin
      acc.ch = MB_CH_W'(slot);
      case (rel[3:0])
        OFF_SEND: acc.kind = ACC_SEND;
        OFF_RECV: acc.kind = ACC_RECV;
        OFF_STAT: acc.kind = ACC_STAT;
        default:  acc.kind = ACC_NONE;
      endcase
    end
  end

endmodule

// File: rtl/dbgmb_channel.sv
module dbgmb_channel #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_push,
  input  logic [DATA_W-1:0] dbg_wdata,
  input  logic              dbg_pop,
  output logic [DATA_W-1:0] c2d_head,
  output logic              c2d_full,
  output logic              c2d_empty,
  output logic              d2c_empty,
  input  logic              core_c2d_valid,
  input  logic [DATA_W-1:0] core_c2d_data,
  output logic              core_c2d_ready,
  output logic              core_d2c_valid,
  output logic [DATA_W-1:0] core_d2c_data,
  input  logic              core_d2c_ready
);

  logic d2c_full_unused;

  dbgmb_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_c2d (
    .clk(clk), .rst(rst),
    .push(core_c2d_valid), .push_data(core_c2d_data),
    .pop(dbg_pop), .pop_data(c2d_head),
    .full(c2d_full), .empty(c2d_empty)
  );

  dbgmb_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_d2c (
    .clk(clk), .rst(rst),
    .push(dbg_push), .push_data(dbg_wdata),
    .pop(core_d2c_ready), .pop_data(core_d2c_data),
    .full(d2c_full_unused), .empty(d2c_empty)
  );

  assign core_c2d_ready = !c2d_full;
  assign core_d2c_valid = !d2c_empty;

endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import dbgmb_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     dbg_req,
  input  logic                     dbg_we,
  input  logic [ADDR_W-1:0]        dbg_addr,
  input  logic [DATA_W-1:0]        dbg_wdata,
  output logic                     dbg_rvalid,
  output logic [DATA_W-1:0]        dbg_rdata,
  input  logic [NUM_CH-1:0]        c2d_valid,
  input  logic [NUM_CH*DATA_W-1:0] c2d_data,
  output logic [NUM_CH-1:0]        c2d_ready,
  output logic [NUM_CH-1:0]        d2c_valid,
  output logic [NUM_CH*DATA_W-1:0] d2c_data,
  input  logic [NUM_CH-1:0]        d2c_ready
);

  localparam logic [DATA_W-1:0] CAP_MASK = DATA_W'((64'd1 << NUM_CH) - 64'd1);

  acc_t              acc;
  logic              rd_req, wr_req;
  logic [NUM_CH-1:0] push_v, pop_v;
  logic [NUM_CH-1:0] c2d_full_v, c2d_empty_v, d2c_empty_v;
  logic [DATA_W-1:0] c2d_head [NUM_CH];
  logic [DATA_W-1:0] rd_mux;

  assign rd_req = dbg_req && !dbg_we;
  assign wr_req = dbg_req && dbg_we;

  dbgmb_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr(dbg_addr),
    .acc (acc)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign push_v[i] = wr_req && acc.kind == ACC_SEND && acc.ch == MB_CH_W'(i);
    assign pop_v[i]  = rd_req && acc.kind == ACC_RECV && acc.ch == MB_CH_W'(i);

    dbgmb_channel #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chan (
      .clk           (clk),
      .rst           (rst),
      .dbg_push      (push_v[i]),
      .dbg_wdata     (dbg_wdata),
      .dbg_pop       (pop_v[i]),
      .c2d_head      (c2d_head[i]),
      .c2d_full      (c2d_full_v[i]),
      .c2d_empty     (c2d_empty_v[i]),
      .d2c_empty     (d2c_empty_v[i]),
      .core_c2d_valid(c2d_valid[i]),
      .core_c2d_data (c2d_data[i*DATA_W +: DATA_W]),
      .core_c2d_ready(c2d_ready[i]),
      .core_d2c_valid(d2c_valid[i]),
      .core_d2c_data (d2c_data[i*DATA_W +: DATA_W]),
      .core_d2c_ready(d2c_ready[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (acc.ch == MB_CH_W'(i)) begin
        case (acc.kind)
          ACC_RECV: rd_mux = c2d_empty_v[i] ? '0 : c2d_head[i];
          ACC_STAT: rd_mux = DATA_W'({!c2d_full_v[i], !d2c_empty_v[i]});
          default:  ;
        endcase
      end
    end
    if (acc.kind == ACC_CAP) rd_mux = CAP_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_rvalid <= 1'b0;
      dbg_rdata  <= '0;
    end else begin
      dbg_rvalid <= rd_req;
      dbg_rdata  <= rd_req ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk #(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              dbg_req,
  input logic              dbg_we,
  input logic [ADDR_W-1:0] dbg_addr,
  input logic              dbg_rvalid,
  input logic [DATA_W-1:0] dbg_rdata,
  input logic [NUM_CH-1:0] c2d_ready,
  input logic [NUM_CH-1:0] d2c_valid,
  input logic [NUM_CH-1:0] d2c_ready,
  input logic [NUM_CH-1:0] c2d_empty
);

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (dbg_req && !dbg_we) |=> dbg_rvalid); // R11
  AST_NO_RVALID_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (dbg_req && dbg_we) |=> !dbg_rvalid); // R11

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    localparam logic [ADDR_W-1:0] RECV_A = ADDR_W'('h204 + 'h10 * i);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && !rst) |-> (!d2c_valid[i] && c2d_ready[i])); // R1
    AST_D2C_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
      $rose(d2c_valid[i]) |-> $past(dbg_req && dbg_we)); // R6
    AST_C2D_SPACE_FROM_READ: assert property (@(posedge clk) disable iff (rst)
      $rose(c2d_ready[i]) |-> $past(dbg_req && !dbg_we)); // R7
    AST_D2C_HOLD: assert property (@(posedge clk) disable iff (rst)
      (d2c_valid[i] && !d2c_ready[i]) |=> d2c_valid[i]); // R10
    AST_EMPTY_RECV_ZERO: assert property (@(posedge clk) disable iff (rst)
      (dbg_req && !dbg_we && dbg_addr == RECV_A && c2d_empty[i]) |=> (dbg_rdata == '0)); // R9
  end

endmodule

bind dbg_mailbox dbg_mailbox_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_addr(dbg_addr),
  .dbg_rvalid(dbg_rvalid), .dbg_rdata(dbg_rdata), .c2d_ready(c2d_ready),
  .d2c_valid(d2c_valid), .d2c_ready(d2c_ready), .c2d_empty(c2d_empty_v)
);

// File: tb/dbg_mailbox_tb.sv
module dbg_mailbox_tb;

  localparam int NCH = 2;
  localparam int DW  = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            dbg_req = 1'b0, dbg_we = 1'b0;
  logic [11:0]     dbg_addr = '0;
  logic [DW-1:0]   dbg_wdata = '0;
  logic            dbg_rvalid;
  logic [DW-1:0]   dbg_rdata;
  logic [NCH-1:0]  c2d_valid = '0, c2d_ready, d2c_valid, d2c_ready = '0;
  logic [NCH*DW-1:0] c2d_data = '0, d2c_data;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dbg_mailbox #(.NUM_CH(NCH), .DATA_W(DW), .DEPTH(4), .ADDR_W(12)) u_dut (
    .clk(clk), .rst(rst), .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rvalid(dbg_rvalid), .dbg_rdata(dbg_rdata),
    .c2d_valid(c2d_valid), .c2d_data(c2d_data), .c2d_ready(c2d_ready),
    .d2c_valid(d2c_valid), .d2c_data(d2c_data), .d2c_ready(d2c_ready)
  );

  function automatic logic [11:0] a_send(int ch); return 12'(12'h200 + 16 * ch); endfunction
  function automatic logic [11:0] a_recv(int ch); return 12'(12'h204 + 16 * ch); endfunction
  function automatic logic [11:0] a_stat(int ch); return 12'(12'h208 + 16 * ch); endfunction

  task automatic check(string rq, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [DW-1:0] d);
    @(negedge clk);
    dbg_req = 1; dbg_we = 1; dbg_addr = a; dbg_wdata = d;
    @(negedge clk);
    dbg_req = 0; dbg_we = 0;
    check("R11 no rvalid on write", 32'(dbg_rvalid), 0);
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    dbg_req = 1; dbg_we = 0; dbg_addr = a;
    @(negedge clk);
    dbg_req = 0;
    check("R11 rvalid after read", 32'(dbg_rvalid), 1);
    d = dbg_rdata;
  endtask

  task automatic core_push(int ch, logic [DW-1:0] d);
    @(negedge clk);
    c2d_valid[ch] = 1; c2d_data[ch*DW +: DW] = d;
    @(negedge clk);
    c2d_valid[ch] = 0;
  endtask

  task automatic core_pop(int ch, output logic v, output logic [DW-1:0] d);
    @(negedge clk);
    v = d2c_valid[ch]; d = d2c_data[ch*DW +: DW];
    d2c_ready[ch] = 1;
    @(negedge clk);
    d2c_ready[ch] = 0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] r;
    check("R1 d2c_valid after reset", 32'(d2c_valid), 0);
    check("R1 c2d_ready after reset", 32'(c2d_ready), 3);
    bus_rd(a_stat(0), r); check("R1 status ch0", r, 2);
    bus_rd(a_stat(1), r); check("R1 status ch1", r, 2);
  endtask

  task automatic t_cap();
    logic [DW-1:0] r;
    bus_rd(12'h280, r); check("R5 capability", r, 32'h3);
  endtask

  task automatic t_d2c();
    logic [DW-1:0] r, d; logic v;
    for (int k = 0; k < 4; k++) bus_wr(a_send(0), 32'hA000 + k);
    bus_rd(a_stat(0), r); check("R4 status recv+send ready", r, 3);
    bus_rd(a_stat(1), r); check("R12 other channel untouched", r, 2);
    bus_wr(a_send(0), 32'hDEAD);
    for (int k = 0; k < 4; k++) begin
      core_pop(0, v, d);
      check("R6 d2c valid", 32'(v), 1);
      check("R6 d2c order", d, 32'hA000 + k);
    end
    check("R8 full write dropped", 32'(d2c_valid[0]), 0);
    bus_rd(a_stat(0), r); check("R4 status empty", r, 2);
  endtask

  task automatic t_c2d();
    logic [DW-1:0] r;
    for (int k = 0; k < 4; k++) core_push(1, 32'hB100 + k);
    check("R10 c2d_ready low when full", 32'(c2d_ready[1]), 0);
    check("R12 ch0 still ready", 32'(c2d_ready[0]), 1);
    bus_rd(a_stat(1), r); check("R3 status full", r, 0);
    for (int k = 0; k < 4; k++) begin
      bus_rd(a_recv(1), r); check("R7 c2d order", r, 32'hB100 + k);
    end
    bus_rd(a_recv(1), r); check("R9 empty read zero", r, 0);
    bus_rd(a_stat(1), r); check("R3 status after drain", r, 2);
    core_push(1, 32'hB200);
    bus_rd(a_recv(0), r); check("R2 ch0 recv empty", r, 0);
    bus_rd(a_recv(1), r); check("R9 empty read did not disturb", r, 32'hB200);
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] r;
    bus_wr(12'h20C, 32'h1111);
    bus_wr(12'h220, 32'h2222);
    bus_wr(12'h300, 32'h3333);
    check("R14 writes ignored", 32'(d2c_valid), 0);
    bus_rd(12'h300, r); check("R14 unmapped read", r, 0);
    bus_rd(12'h228, r); check("R14 absent channel status", r, 0);
    bus_rd(12'h20C, r); check("R14 unused offset", r, 0);
  endtask

  task automatic t_same_cycle();
    logic [DW-1:0] r, d; logic v;
    for (int k = 0; k < 3; k++) core_push(0, 32'hC000 + k);
    @(negedge clk);
    dbg_req = 1; dbg_we = 0; dbg_addr = a_recv(0);
    c2d_valid[0] = 1; c2d_data[0 +: DW] = 32'hC003;
    @(negedge clk);
    dbg_req = 0; c2d_valid[0] = 0;
    check("R13 simultaneous pop word", dbg_rdata, 32'hC000);
    bus_rd(a_stat(0), r); check("R13 level kept", r, 2);
    for (int k = 1; k < 4; k++) begin
      bus_rd(a_recv(0), r); check("R13 order after overlap", r, 32'hC000 + k);
    end
    for (int k = 0; k < 4; k++) bus_wr(a_send(1), 32'hD000 + k);
    @(negedge clk);
    dbg_req = 1; dbg_we = 1; dbg_addr = a_send(1); dbg_wdata = 32'hDEAD;
    v = d2c_valid[1]; d = d2c_data[DW +: DW]; d2c_ready[1] = 1;
    @(negedge clk);
    dbg_req = 0; dbg_we = 0; d2c_ready[1] = 0;
    check("R13 core pop during write", d, 32'hD000);
    for (int k = 1; k < 4; k++) begin
      core_pop(1, v, d); check("R8 drain order", d, 32'hD000 + k);
    end
    check("R8 write on full dropped", 32'(d2c_valid[1]), 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;
    t_reset();
    t_cap();
    t_d2c();
    t_c2d();
    t_unmapped();
    t_same_cycle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule